// File: doc/BRIEF.md
# Host Serial Transceiver with Modem Handshake

This block is a full-duplex asynchronous serial link to a host. Its transmitter and receiver run at the same time and share one baud generator. The generator produces a clock enable at sixteen times the bit rate from a programmable divisor. The host hands over bytes through a valid/ready pair on the transmit side. It collects received bytes from a one-byte holding register, which carries parity and framing error flags.

Two frame profiles can be selected. The command profile always sends and expects eight data bits with no parity and a single stop bit, whatever the flexible-profile settings are. The flexible profile offers seven or eight data bits and even or odd parity. Its stop period is one, one and a half or two bit times. Flow control is done in hardware. The clear-to-send input holds back the start of a new transmit frame. The request-to-send output drops while a received byte waits to be read. The terminal-ready output and data-set-ready input are plain levels: one is registered from the host, the other is synchronised to the host.

Top module: `host_uart`

## Requirements
- R1: After reset, txd is high, txReady is high when ctsIn is high, rxValid is low, rtsOut is high and dtrOut is low.
- R2: One bit time is 16 ticks and one tick lasts `divisor` clocks (0 acts as 1). With profileFlex=0 every frame is start (low), 8 data bits LSB first and one high stop bit, whatever flexWide, parityOdd and stopSel hold.
- R3: With profileFlex=1 the frame carries 7 (flexWide=0, bits 6..0) or 8 (flexWide=1) data bits LSB first, then one parity bit. parityOdd=0 makes the count of ones over data plus parity even; parityOdd=1 makes it odd.
- R4: The transmit stop period lasts 16, 24 or 32 ticks for stopSel 0, 1 and 2 or 3 in the flexible profile, and 16 ticks in the command profile. txReady rises in the cycle the stop period ends.
- R5: While ctsIn is low, txReady is low and no frame starts; txd stays high even with txValid held.
- R6: A frame already started completes with correct bits if ctsIn falls during it.
- R7: The receiver samples each bit near its centre and assembles data LSB first. In 7-bit mode rxData[7] reads 0.
- R8: A low pulse on rxd shorter than half a bit is rejected as a start bit, and no byte is delivered.
- R9: rxParErr is set with the byte when the received parity bit disagrees with the configured parity; it is always 0 in the command profile.
- R10: rxFrameErr is set with the byte when the first stop bit samples low.
- R11: A received byte stays in rxData with rxValid high until a cycle with rxReady high consumes it. rtsOut is low exactly while rxValid is high.
- R12: Transmit and receive frames can overlap in time without affecting each other.
- R13: dtrOut follows dtrDrive one clock later; dsrLevel follows dsrIn through a two-flop synchroniser (two clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Clocks per oversample tick |
| profileFlex | input | 1 | 0 = command profile (8N1), 1 = flexible profile |
| flexWide | input | 1 | Flexible profile: 1 = 8 data bits, 0 = 7 |
| parityOdd | input | 1 | Flexible profile: 1 = odd parity, 0 = even |
| stopSel | input | 2 | Flexible profile stop length: 0 = 1, 1 = 1.5, 2/3 = 2 bits |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | txData is offered |
| txReady | output | 1 | Transmitter accepts a byte this cycle |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | Holding register full |
| rxReady | input | 1 | Host consumes the held byte |
| rxParErr | output | 1 | Parity error for the held byte |
| rxFrameErr | output | 1 | Framing error for the held byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| ctsIn | input | 1 | Clear to send, high = allowed |
| rtsOut | output | 1 | Request to send, high = room for a byte |
| dtrDrive | input | 1 | Host level for terminal-ready |
| dtrOut | output | 1 | Terminal-ready line |
| dsrIn | input | 1 | Data-set-ready line |
| dsrLevel | output | 1 | Synchronised data-set-ready level |

## Verification
The hardest situations are the receive-side rejections. One is a start pulse that ends before mid-bit. The other is a framing error whose low stop bit must not be taken as the start of a new frame. The bench builds both from timed rxd waveforms: a pulse of a few clocks, and a stop bit held low for five eighths of a bit and then released. After each, a clean frame must arrive intact. Stop length on transmit is measured in clocks from the falling start edge to the return of txReady, over every profile and stop setting.

// File: rtl/host_uart_pkg.sv
package host_uart_pkg;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PAR
  } txLine_e;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_WAIT,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } txState_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rxState_e;

  typedef struct packed {
    logic       wide;
    logic       parEn;
    logic       odd;
    logic [1:0] stop;
  } frameCfg_t;

  typedef struct packed {
    logic    txLoad;
    logic    txShift;
    txLine_e txLine;
    logic    rxShift;
    logic    rxParity;
    logic    rxStop;
    logic    rxWide;
    logic    rxParEn;
    logic    rxOdd;
  } strobe_t;

endpackage

// File: rtl/host_uart_baud.sv
module host_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim  = (divisor == '0) ? '0 : divisor - DIV_W'(1);
    tick = (cnt >= lim);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + DIV_W'(1);
  end

  // Ticks are spaced by the divisor: never two in a row unless it is 0 or 1.
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && lim != '0) |=> (!tick || lim == '0));

endmodule

// File: rtl/host_uart_ctrl.sv
module host_uart_ctrl
  import host_uart_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      cts,
  input  logic      txValid,
  output logic      txReady,
  input  frameCfg_t liveCfg,
  input  logic      rxBit,
  output strobe_t   stb
);

  localparam int TCNT_W = $clog2(2 * OS);
  localparam logic [TCNT_W-1:0] BIT_LAST  = TCNT_W'(OS - 1);
  localparam logic [TCNT_W-1:0] HALF_LAST = TCNT_W'(OS / 2 - 1);

  txState_e          txState;
  logic [TCNT_W-1:0] txTick;
  logic [2:0]        txBits;
  logic              txWideQ;
  logic              txParQ;
  logic [1:0]        txStopQ;
  logic [TCNT_W-1:0] stopLast;
  logic [2:0]        txDataLast;

  rxState_e          rxState;
  logic [TCNT_W-1:0] rxTick;
  logic [2:0]        rxBits;
  logic              rxWideQ;
  logic              rxParQ;
  logic              rxOddQ;
  logic [2:0]        rxDataLast;

  always_comb begin
    case (txStopQ)
      2'd0:    stopLast = TCNT_W'(OS - 1);
      2'd1:    stopLast = TCNT_W'(OS + OS / 2 - 1);
      default: stopLast = TCNT_W'(2 * OS - 1);
    endcase
    txDataLast = txWideQ ? 3'd7 : 3'd6;
    rxDataLast = rxWideQ ? 3'd7 : 3'd6;
  end

  // Strobes toward the datapath
  always_comb begin
    txReady     = (txState == TX_IDLE) && cts;
    stb.txLoad  = txValid && txReady;
    stb.txShift = (txState == TX_DATA) && tick && (txTick == BIT_LAST);
    case (txState)
      TX_START: stb.txLine = LINE_SPACE;
      TX_DATA:  stb.txLine = LINE_DATA;
      TX_PAR:   stb.txLine = LINE_PAR;
      default:  stb.txLine = LINE_MARK;
    endcase
    stb.rxShift  = (rxState == RX_DATA) && tick && (rxTick == BIT_LAST);
    stb.rxParity = (rxState == RX_PAR)  && tick && (rxTick == BIT_LAST);
    stb.rxStop   = (rxState == RX_STOP) && tick && (rxTick == BIT_LAST);
    stb.rxWide   = rxWideQ;
    stb.rxParEn  = rxParQ;
    stb.rxOdd    = rxOddQ;
  end

  // Transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txTick  <= '0;
      txBits  <= '0;
      txWideQ <= 1'b1;
      txParQ  <= 1'b0;
      txStopQ <= 2'd0;
    end else begin
      case (txState)
        TX_IDLE: if (stb.txLoad) begin
          txWideQ <= liveCfg.wide;
          txParQ  <= liveCfg.parEn;
          txStopQ <= liveCfg.stop;
          txState <= TX_WAIT;
        end
        TX_WAIT: if (tick) begin
          txTick  <= '0;
          txState <= TX_START;
        end
        TX_START: if (tick) begin
          if (txTick == BIT_LAST) begin
            txTick  <= '0;
            txBits  <= '0;
            txState <= TX_DATA;
          end else txTick <= txTick + 1'b1;
        end
        TX_DATA: if (tick) begin
          if (txTick == BIT_LAST) begin
            txTick <= '0;
            if (txBits == txDataLast) txState <= txParQ ? TX_PAR : TX_STOP;
            else txBits <= txBits + 1'b1;
          end else txTick <= txTick + 1'b1;
        end
        TX_PAR: if (tick) begin
          if (txTick == BIT_LAST) begin
            txTick  <= '0;
            txState <= TX_STOP;
          end else txTick <= txTick + 1'b1;
        end
        TX_STOP: if (tick) begin
          if (txTick == stopLast) begin
            txTick  <= '0;
            txState <= TX_IDLE;
          end else txTick <= txTick + 1'b1;
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  // Receive sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxBits  <= '0;
      rxWideQ <= 1'b1;
      rxParQ  <= 1'b0;
      rxOddQ  <= 1'b0;
    end else begin
      case (rxState)
        RX_IDLE: if (tick && !rxBit) begin
          rxWideQ <= liveCfg.wide;
          rxParQ  <= liveCfg.parEn;
          rxOddQ  <= liveCfg.odd;
          rxTick  <= '0;
          rxState <= RX_START;
        end
        RX_START: if (tick) begin
          if (rxTick == HALF_LAST) begin
            rxTick  <= '0;
            rxBits  <= '0;
            rxState <= rxBit ? RX_IDLE : RX_DATA;
          end else rxTick <= rxTick + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (rxTick == BIT_LAST) begin
            rxTick <= '0;
            if (rxBits == rxDataLast) rxState <= rxParQ ? RX_PAR : RX_STOP;
            else rxBits <= rxBits + 1'b1;
          end else rxTick <= rxTick + 1'b1;
        end
        RX_PAR: if (tick) begin
          if (rxTick == BIT_LAST) begin
            rxTick  <= '0;
            rxState <= RX_STOP;
          end else rxTick <= rxTick + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (rxTick == BIT_LAST) begin
            rxTick  <= '0;
            rxState <= RX_IDLE;
          end else rxTick <= rxTick + 1'b1;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // A frame only returns to idle through its stop period.
  assert_frame_completes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_IDLE && $past(txState) != TX_IDLE) |-> ($past(txState) == TX_STOP));

  // No frame leaves idle while clear-to-send is low.
  assert_cts_holds_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_IDLE && !cts) |=> (txState == TX_IDLE));

  // A start bit that is high again at mid-bit sends the receiver back to idle.
  assert_false_start_dropped_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_START && tick && rxTick == HALF_LAST && rxBit) |=> (rxState == RX_IDLE));

endmodule

// File: rtl/host_uart_dp.sv
module host_uart_dp
  import host_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic       txWide,
  input  logic       txOdd,
  input  logic [7:0] txData,
  output logic       txd,
  input  logic       rxd,
  output logic       rxBit,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  output logic       rxParErr,
  output logic       rxFrameErr,
  input  logic       dtrDrive,
  output logic       dtrOut,
  input  logic       dsrIn,
  output logic       dsrLevel
);

  logic [7:0] txShiftReg;
  logic       txParBit;
  logic [1:0] rxSync;
  logic [1:0] dsrSync;
  logic [7:0] rxShiftReg;
  logic [7:0] rxAligned;
  logic       parPend;

  assign rxBit    = rxSync[1];
  assign dsrLevel = dsrSync[1];

  always_comb begin
    rxAligned = stb.rxWide ? rxShiftReg : {1'b0, rxShiftReg[7:1]};
  end

  // Transmit path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftReg <= '0;
      txParBit   <= 1'b0;
      txd        <= 1'b1;
    end else begin
      if (stb.txLoad) begin
        txShiftReg <= txData;
        txParBit   <= txOdd ^ (^(txWide ? txData : {1'b0, txData[6:0]}));
      end else if (stb.txShift) begin
        txShiftReg <= {1'b0, txShiftReg[7:1]};
      end
      case (stb.txLine)
        LINE_SPACE: txd <= 1'b0;
        LINE_DATA:  txd <= txShiftReg[0];
        LINE_PAR:   txd <= txParBit;
        default:    txd <= 1'b1;
      endcase
    end
  end

  // Receive path and holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync     <= 2'b11;
      rxShiftReg <= '0;
      parPend    <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxParErr   <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxd};
      if (stb.rxShift) rxShiftReg <= {rxBit, rxShiftReg[7:1]};
      if (stb.rxParity) parPend <= rxBit ^ stb.rxOdd ^ (^rxAligned);
      if (stb.rxStop) begin
        rxData     <= rxAligned;
        rxValid    <= 1'b1;
        rxParErr   <= stb.rxParEn & parPend;
        rxFrameErr <= ~rxBit;
      end else if (rxValid && rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  // Handshake levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dtrOut  <= 1'b0;
      dsrSync <= 2'b00;
    end else begin
      dtrOut  <= dtrDrive;
      dsrSync <= {dsrSync[0], dsrIn};
    end
  end

  // A 7-bit frame never delivers a set top bit.
  assert_seven_bit_top_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxStop && !stb.rxWide) |=> !rxData[7]);

  // The held byte stays put until the host takes it.
  assert_hold_until_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !stb.rxStop) |=> (rxValid && $stable(rxData)));

endmodule

// File: rtl/host_uart.sv
module host_uart
  import host_uart_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OS    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             profileFlex,
  input  logic             flexWide,
  input  logic             parityOdd,
  input  logic [1:0]       stopSel,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic             rxParErr,
  output logic             rxFrameErr,
  output logic             txd,
  input  logic             rxd,
  input  logic             ctsIn,
  output logic             rtsOut,
  input  logic             dtrDrive,
  output logic             dtrOut,
  input  logic             dsrIn,
  output logic             dsrLevel
);

  frameCfg_t liveCfg;
  strobe_t   stb;
  logic      tick;
  logic      rxBit;

  always_comb begin
    if (profileFlex) begin
      liveCfg.wide  = flexWide;
      liveCfg.parEn = 1'b1;
      liveCfg.odd   = parityOdd;
      liveCfg.stop  = stopSel;
    end else begin
      liveCfg.wide  = 1'b1;
      liveCfg.parEn = 1'b0;
      liveCfg.odd   = 1'b0;
      liveCfg.stop  = 2'd0;
    end
  end

  assign rtsOut = ~rxValid;

  host_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rstN    (rstN),
    .divisor (divisor),
    .tick    (tick)
  );

  host_uart_ctrl #(.OS(OS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .cts     (ctsIn),
    .txValid (txValid),
    .txReady (txReady),
    .liveCfg (liveCfg),
    .rxBit   (rxBit),
    .stb     (stb)
  );

  host_uart_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .txWide     (liveCfg.wide),
    .txOdd      (liveCfg.odd),
    .txData     (txData),
    .txd        (txd),
    .rxd        (rxd),
    .rxBit      (rxBit),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxReady    (rxReady),
    .rxParErr   (rxParErr),
    .rxFrameErr (rxFrameErr),
    .dtrDrive   (dtrDrive),
    .dtrOut     (dtrOut),
    .dsrIn      (dsrIn),
    .dsrLevel   (dsrLevel)
  );

  // Line is high in every cycle that follows an idle transmitter cycle with no load.
  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !txValid) |=> txd);

endmodule

// File: tb/host_uart_bench.sv
module host_uart_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divisor = 16'd2;
  logic        profileFlex = 1'b0;
  logic        flexWide = 1'b1;
  logic        parityOdd = 1'b0;
  logic [1:0]  stopSel = 2'd0;
  logic [7:0]  txData = 8'h00;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        rxReady = 1'b0;
  logic        rxParErr;
  logic        rxFrameErr;
  logic        txd;
  logic        rxd = 1'b1;
  logic        ctsIn = 1'b1;
  logic        rtsOut;
  logic        dtrDrive = 1'b0;
  logic        dtrOut;
  logic        dsrIn = 1'b0;
  logic        dsrLevel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  host_uart u_host_uart (
    .clk(clk), .rstN(rstN), .divisor(divisor), .profileFlex(profileFlex),
    .flexWide(flexWide), .parityOdd(parityOdd), .stopSel(stopSel),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .rxParErr(rxParErr), .rxFrameErr(rxFrameErr), .txd(txd), .rxd(rxd),
    .ctsIn(ctsIn), .rtsOut(rtsOut), .dtrDrive(dtrDrive), .dtrOut(dtrOut),
    .dsrIn(dsrIn), .dsrLevel(dsrLevel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finishRun();
    end
  end

  function automatic int nData();
    return (!profileFlex || flexWide) ? 8 : 7;
  endfunction
  function automatic int stopTicks();
    if (!profileFlex) return 16;
    return (stopSel == 2'd0) ? 16 : (stopSel == 2'd1) ? 24 : 32;
  endfunction
  function automatic int bitClk();
    return 16 * ((divisor == 0) ? 1 : int'(divisor));
  endfunction
  function automatic logic [7:0] maskData(input logic [7:0] d);
    return (nData() == 8) ? d : {1'b0, d[6:0]};
  endfunction
  function automatic logic parOf(input logic [7:0] d);
    return parityOdd ^ (^maskData(d));
  endfunction

  task automatic stepN(input int k, inout int n);
    repeat (k) @(negedge clk);
    n += k;
  endtask

  task automatic txSend(input logic [7:0] d);
    while (!txReady) @(negedge clk);
    txData  = d;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic txMonitor(input logic [7:0] d, input string req);
    int n = 0;
    int nd = nData();
    int np = profileFlex ? 1 : 0;
    int total = bitClk() * (1 + nd + np) + stopTicks() * (bitClk() / 16);
    logic [7:0] got = '0;
    logic gotPar = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    stepN(bitClk() / 2, n);
    check(txd == 1'b0, {req, " start bit low"}, int'(txd), 0);
    for (int i = 0; i < nd; i++) begin
      stepN(bitClk(), n);
      got[i] = txd;
    end
    check(got == maskData(d), {req, " data bits"}, int'(got), int'(maskData(d)));
    if (np == 1) begin
      stepN(bitClk(), n);
      gotPar = txd;
      check(gotPar == parOf(d), "R3 parity bit", int'(gotPar), int'(parOf(d)));
    end
    stepN(bitClk(), n);
    check(txd == 1'b1, "R2 stop bit high", int'(txd), 1);
    while (!txReady) stepN(1, n);
    check(n == total - 1, "R4 stop length to ready", n, total - 1);
  endtask

  task automatic driveBits(input logic v, input int k);
    rxd = v;
    repeat (k) @(negedge clk);
  endtask

  task automatic rxFrame(input logic [7:0] d, input bit badPar, input bit badStop);
    int nd = nData();
    logic [7:0] exp = maskData(d);
    driveBits(1'b0, bitClk());
    for (int i = 0; i < nd; i++) driveBits(d[i], bitClk());
    if (profileFlex) driveBits(parOf(d) ^ badPar, bitClk());
    if (badStop) begin
      driveBits(1'b0, bitClk() * 5 / 8);
      driveBits(1'b1, bitClk() - bitClk() * 5 / 8);
    end else begin
      driveBits(1'b1, stopTicks() * (bitClk() / 16));
    end
    driveBits(1'b1, bitClk());
    check(rxValid == 1'b1, "R7 byte delivered", int'(rxValid), 1);
    check(rxData == exp, "R7 received data", int'(rxData), int'(exp));
    check(rxParErr == (profileFlex && badPar), "R9 parity flag", int'(rxParErr),
          int'(profileFlex && badPar));
    check(rxFrameErr == badStop, "R10 framing flag", int'(rxFrameErr), int'(badStop));
    check(rtsOut == 1'b0, "R11 rts low while full", int'(rtsOut), 0);
    repeat (40) @(negedge clk);
    check(rxValid == 1'b1 && rxData == exp, "R11 byte held", int'(rxData), int'(exp));
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
    check(rxValid == 1'b0 && rtsOut == 1'b1, "R11 consumed", int'(rxValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    check(txReady == 1'b1, "R1 txReady", int'(txReady), 1);
    check(rxValid == 1'b0, "R1 rxValid", int'(rxValid), 0);
    check(rtsOut == 1'b1, "R1 rtsOut", int'(rtsOut), 1);
    check(dtrOut == 1'b0, "R1 dtrOut", int'(dtrOut), 0);

    // Sweep: command profile (with odd flexible settings that must be ignored) and all flexible configurations
    for (int idx = 0; idx < 13; idx++) begin
      if (idx == 0) begin
        profileFlex = 1'b0; flexWide = 1'b0; parityOdd = 1'b1; stopSel = 2'd2;
      end else begin
        profileFlex = 1'b1;
        flexWide  = ((idx - 1) % 2) != 0;
        parityOdd = (((idx - 1) / 2) % 2) != 0;
        stopSel   = 2'((idx - 1) / 4);
      end
      for (int k = 0; k < 3; k++) begin
        logic [7:0] d = 8'(idx * 37 + k * 91 + 5);
        txSend(d);
        txMonitor(d, profileFlex ? "R3" : "R2");
      end
      for (int k = 0; k < 2; k++) rxFrame(8'(idx * 53 + k * 77 + 200), 1'b0, 1'b0);
      rxFrame(8'hA6, 1'b1, 1'b0);
      rxFrame(8'h5B, 1'b0, 1'b1);
    end

    // R5: clear-to-send low blocks a new frame
    profileFlex = 1'b0;
    ctsIn = 1'b0;
    @(negedge clk);
    txData = 8'hC3;
    txValid = 1'b1;
    begin
      int lowSeen = 0;
      int readySeen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (txd == 1'b0) lowSeen++;
        if (txReady) readySeen++;
      end
      check(lowSeen == 0, "R5 txd held high", lowSeen, 0);
      check(readySeen == 0, "R5 txReady low", readySeen, 0);
    end
    ctsIn = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    txMonitor(8'hC3, "R5");

    // R6: clear-to-send drops mid-frame
    profileFlex = 1'b1; flexWide = 1'b1; parityOdd = 1'b0; stopSel = 2'd0;
    txSend(8'h96);
    fork
      txMonitor(8'h96, "R6");
      begin
        repeat (100) @(negedge clk);
        ctsIn = 1'b0;
        repeat (100) @(negedge clk);
        ctsIn = 1'b1;
      end
    join

    // R8: short low pulse is not a start bit
    driveBits(1'b0, 6);
    driveBits(1'b1, 400);
    check(rxValid == 1'b0, "R8 glitch rejected", int'(rxValid), 0);
    rxFrame(8'h3E, 1'b0, 1'b0);

    // R12: overlapping transmit and receive frames
    profileFlex = 1'b1; flexWide = 1'b0; parityOdd = 1'b1; stopSel = 2'd1;
    txSend(8'h71);
    fork
      txMonitor(8'h71, "R12");
      rxFrame(8'h4D, 1'b0, 1'b0);
    join

    // R2: a different divisor, command profile
    divisor = 16'd3;
    profileFlex = 1'b0;
    repeat (10) @(negedge clk);
    txSend(8'hE1);
    txMonitor(8'hE1, "R2");
    rxFrame(8'h1F, 1'b0, 1'b0);

    // R13: handshake levels
    dtrDrive = 1'b1;
    @(negedge clk);
    check(dtrOut == 1'b1, "R13 dtr follows", int'(dtrOut), 1);
    dsrIn = 1'b1;
    @(negedge clk);
    check(dsrLevel == 1'b0, "R13 dsr still syncing", int'(dsrLevel), 0);
    @(negedge clk);
    check(dsrLevel == 1'b1, "R13 dsr after sync", int'(dsrLevel), 1);
    dtrDrive = 1'b0;
    dsrIn = 1'b0;
    repeat (2) @(negedge clk);
    check(dtrOut == 1'b0 && dsrLevel == 1'b0, "R13 levels return low", int'(dsrLevel), 0);

    finishRun();
  end

endmodule